// File: doc/BRIEF.md
# Composite Memory Select Combiner

This block merges four active-low memory-select strobes (program, data, boot and I/O) into one composite active-low chip select. The strobes come from the address decode logic elsewhere in the chip. A software-writable enable mask chooses which of them drive the composite output. The output is combinational from the strobes, so it has exactly the timing of whichever enabled strobe is active. One external memory can then answer in more than one address space. For example, the program and data strobes can share one device, with one of the individual strobes used as an extra address bit.

The mask has one enable bit per strobe. At reset every source is enabled except boot. A write to the mask never changes the active mask in the middle of an access. A write made while every strobe is high takes effect at that clock edge. A write made while any strobe is low is held back and applied at the first later edge at which all strobes are high. The readback port always returns the most recently written mask, with unused upper bits reading zero.

While the external bus is granted to another master, the composite select is forced high, just like the individual selects. In the default variant it also drops its output enable, so a pad can float it. The other variant keeps driving it high.

Top module: `memsel_merge`

## Requirements
- R1: After reset the active mask is 0b1011 and the readback is 0x0B. The bit order is bit 0 program, bit 1 data, bit 2 boot, bit 3 I/O, so a lone low boot strobe leaves the composite high.
- R2: With the bus not granted, the composite select is low in the same cycle as any strobe that is low and enabled in the active mask. It needs no clock edge.
- R3: A low strobe whose enable bit is 0 has no effect. The composite stays high unless another enabled strobe is low.
- R4: With all strobes high the composite is high. With several enabled strobes low together it is low.
- R5: A mask write at a clock edge where all four strobes are high sets the active mask at that edge.
- R6: A mask write at an edge where any strobe is low leaves the active mask unchanged. The active mask does not change at any edge with a strobe low. A held write is applied at the first edge where all strobes are high.
- R7: The readback returns the last written mask in its low four bits and zero in every bit above them, whether or not that write has yet become active.
- R8: While the bus-grant input is high, the composite select is high whatever the strobes and the mask are.
- R9: In the default float variant, the output enable is low while the bus is granted and high otherwise.
- R10: When several writes arrive while a strobe is low, the last of them is the one applied once the strobes go idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 4 | Individual active-low strobes: bit 0 program, 1 data, 2 boot, 3 I/O |
| bus_granted | input | 1 | High while another master owns the external bus |
| mask_we | input | 1 | Mask write strobe, sampled on the clock edge |
| mask_wdata | input | 4 | New enable mask, same bit order as sel_n |
| mask_rdata | output | 8 | Last written mask, upper bits zero |
| comp_sel_n | output | 1 | Composite active-low select |
| comp_oe | output | 1 | Output enable for the composite select pad |

## Verification
The combiner is driven with single low strobes, with several low strobes together, and with all strobes idle, under both the reset mask and written masks. A single low strobe separates enabled sources from disabled ones. Several low strobes together expose a mask that is merged with AND where it should be OR. Mask writes are placed both at idle edges and at busy edges, including back-to-back writes during one access. Comparing the output before and after the following idle edge separates immediate application from deferred application, and shows which held value wins. Bus-grant cycles come with low strobes, so any leak of a strobe through the grant override shows up. Seeded random traffic then mixes all of these against a bench model of the active, held and shadow masks.

// File: rtl/cms_pkg.sv
package cms_pkg;

   typedef enum logic [1:0] {
      SRC_PROG = 2'd0,
      SRC_DATA = 2'd1,
      SRC_BOOT = 2'd2,
      SRC_IO   = 2'd3
   } cms_src_e;

   // Reset mask: every source enabled except the boot select.
   function automatic logic [31:0] cms_default_mask(input int unsigned n);
      logic [31:0] all_ones;
      all_ones = (32'h1 << n) - 32'h1;
      return all_ones & ~(32'h1 << int'(SRC_BOOT));
   endfunction

endpackage

// File: rtl/cms_mask_reg.sv
module cms_mask_reg #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned REG_W   = 8,
   parameter logic [NUM_SRC-1:0] RESET_MASK = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [NUM_SRC-1:0] wdata,
   input  logic               bus_idle,
   output logic [NUM_SRC-1:0] active,
   output logic [REG_W-1:0]   rdata
);

   localparam int unsigned PAD_W = REG_W - NUM_SRC;

   logic [NUM_SRC-1:0] active_q;
   logic [NUM_SRC-1:0] shadow_q;
   logic [NUM_SRC-1:0] held_q;
   logic               held_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= RESET_MASK;
         shadow_q   <= RESET_MASK;
         held_q     <= RESET_MASK;
         held_vld_q <= 1'b0;
      end else begin
         if (we) begin
            shadow_q <= wdata;
         end
         if (bus_idle) begin
            if (we) begin
               active_q <= wdata;
            end else if (held_vld_q) begin
               active_q <= held_q;
            end
            held_vld_q <= 1'b0;
         end else if (we) begin
            held_q     <= wdata;
            held_vld_q <= 1'b1;
         end
      end
   end

   assign active = active_q;

   generate
      if (PAD_W == 0) begin : g_rd_exact
         assign rdata = shadow_q;
      end else begin : g_rd_pad
         assign rdata = {{PAD_W{1'b0}}, shadow_q};
      end
   endgenerate

   // R1: first cycle out of reset shows the reset mask
   p_reset_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> active_q == RESET_MASK);

   // R6: active mask frozen across any busy edge
   p_mask_frozen_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_idle |=> $stable(active_q));

   // R6: a held write is retired at the first idle edge
   p_held_retired_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (held_vld_q && bus_idle) |=> !held_vld_q);

endmodule

// File: rtl/cms_merge.sv
module cms_merge #(
   parameter int unsigned NUM_SRC = 4
) (
   input  logic [NUM_SRC-1:0] sel_n,
   input  logic [NUM_SRC-1:0] enable,
   output logic               any_hit
);

   logic [NUM_SRC-1:0] hit;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign hit[i] = ~sel_n[i] & enable[i];
      end
   endgenerate

   assign any_hit = |hit;

   // R3: no hit is ever reported for a source whose strobe is idle
   always_comb begin
      p_hit_needs_strobe_r3: assert (!any_hit || !(&sel_n));
   end

endmodule

// File: rtl/cms_drive.sv
module cms_drive #(
   parameter bit FLOAT_ON_GRANT = 1'b1
) (
   input  logic any_hit,
   input  logic bus_granted,
   output logic sel_n_o,
   output logic oe_o
);

   assign sel_n_o = bus_granted | ~any_hit;

   generate
      if (FLOAT_ON_GRANT) begin : g_float
         assign oe_o = ~bus_granted;
      end else begin : g_drive_high
         assign oe_o = 1'b1;
      end
   endgenerate

   // R8: granted bus never sees the composite asserted
   always_comb begin
      p_grant_deasserts_r8: assert (!bus_granted || sel_n_o);
   end

endmodule

// File: rtl/memsel_merge.sv
module memsel_merge #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned REG_W   = 8,
   parameter bit          FLOAT_ON_GRANT = 1'b1,
   parameter logic [NUM_SRC-1:0] RESET_MASK =
      NUM_SRC'(cms_pkg::cms_default_mask(NUM_SRC))
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] sel_n,
   input  logic               bus_granted,
   input  logic               mask_we,
   input  logic [NUM_SRC-1:0] mask_wdata,
   output logic [REG_W-1:0]   mask_rdata,
   output logic               comp_sel_n,
   output logic               comp_oe
);

   generate
      if (NUM_SRC <= int'(cms_pkg::SRC_IO)) begin : g_chk_src
         $error("NUM_SRC must cover all four named selects");
      end
      if (NUM_SRC > 31) begin : g_chk_src_max
         $error("NUM_SRC above 31 is not supported");
      end
      if (REG_W < NUM_SRC || REG_W > 32) begin : g_chk_reg
         $error("REG_W must be between NUM_SRC and 32");
      end
   endgenerate

   logic               bus_idle;
   logic [NUM_SRC-1:0] active_mask;
   logic               any_hit;

   assign bus_idle = &sel_n;

   cms_mask_reg #(
      .NUM_SRC   (NUM_SRC),
      .REG_W     (REG_W),
      .RESET_MASK(RESET_MASK)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (mask_we),
      .wdata   (mask_wdata),
      .bus_idle(bus_idle),
      .active  (active_mask),
      .rdata   (mask_rdata)
   );

   cms_merge #(
      .NUM_SRC(NUM_SRC)
   ) u_merge (
      .sel_n  (sel_n),
      .enable (active_mask),
      .any_hit(any_hit)
   );

   cms_drive #(
      .FLOAT_ON_GRANT(FLOAT_ON_GRANT)
   ) u_drive (
      .any_hit    (any_hit),
      .bus_granted(bus_granted),
      .sel_n_o    (comp_sel_n),
      .oe_o       (comp_oe)
   );

   // R4: composite only asserts while some individual strobe is low
   p_comp_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !comp_sel_n |-> !(&sel_n));

   // R8: grant at the port always shows a deasserted composite
   p_grant_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_granted |-> comp_sel_n);

   // R7: readback upper bits are zero
   p_rd_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_rdata >> NUM_SRC) == '0);

endmodule

// File: tb/memsel_merge_test.sv
module memsel_merge_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] sel_n = 4'hF;
   logic       bus_granted = 1'b0;
   logic       mask_we = 1'b0;
   logic [3:0] mask_wdata = 4'h0;
   logic [7:0] mask_rdata;
   logic       comp_sel_n;
   logic       comp_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [3:0] m_active, m_shadow, m_held;
   bit         m_held_vld;

   always #5 clk = ~clk;

   memsel_merge uut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .bus_granted(bus_granted),
      .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
      .comp_sel_n(comp_sel_n), .comp_oe(comp_oe)
   );

   function automatic logic exp_comp(logic [3:0] s, logic [3:0] m, logic g);
      return g | ~(|(~s & m));
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(logic [3:0] s, logic g, logic we, logic [3:0] wd, string tag);
      string t;
      logic  e;
      @(negedge clk);
      sel_n = s; bus_granted = g; mask_we = we; mask_wdata = wd;
      #2;
      e = exp_comp(s, m_active, g);
      if (tag != "") t = tag;
      else if (g) t = "R8";
      else if (!e) t = "R2";
      else if (!(&s)) t = "R3";
      else t = "R4";
      check(t, {7'd0, comp_sel_n}, {7'd0, e});
      check("R9", {7'd0, comp_oe}, {7'd0, ~g});
      check("R7", mask_rdata, {4'd0, m_shadow});
      @(posedge clk);
      if (we) m_shadow = wd;
      if (&s) begin
         if (we) m_active = wd;
         else if (m_held_vld) m_active = m_held;
         m_held_vld = 1'b0;
      end else if (we) begin
         m_held = wd;
         m_held_vld = 1'b1;
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_active = 4'b1011; m_shadow = 4'b1011; m_held = 4'b1011; m_held_vld = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      check("R1", mask_rdata, 8'h0B);
      check("R1", {7'd0, comp_sel_n}, 8'd1);
      // R1: boot disabled at reset
      step(4'b1011, 0, 0, 4'h0, "R1");
      step(4'b1110, 0, 0, 4'h0, "R2");
      step(4'b0101, 0, 0, 4'h0, "R4");
      step(4'b1111, 0, 0, 4'h0, "R4");
      // R5: write while idle
      step(4'b1111, 0, 1, 4'b0100, "R5");
      step(4'b1011, 0, 0, 4'h0, "R5");
      step(4'b1110, 0, 0, 4'h0, "R5");
      // R6: write while busy is held back
      step(4'b1011, 0, 1, 4'b0001, "R6");
      step(4'b1110, 0, 0, 4'h0, "R6");
      step(4'b1111, 0, 0, 4'h0, "R6");
      step(4'b1110, 0, 0, 4'h0, "R6");
      step(4'b1011, 0, 0, 4'h0, "R6");
      // R10: last held write wins
      step(4'b1110, 0, 1, 4'b0010, "R10");
      step(4'b1110, 0, 1, 4'b1000, "R10");
      step(4'b1111, 0, 0, 4'h0, "R10");
      step(4'b1101, 0, 0, 4'h0, "R10");
      step(4'b0111, 0, 0, 4'h0, "R10");
      // R8/R9: grant overrides an enabled low strobe
      step(4'b0111, 1, 0, 4'h0, "R8");
      step(4'b0000, 1, 0, 4'h0, "R8");
      step(4'b0111, 0, 0, 4'h0, "R2");
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] s;
         logic       g, we;
         s  = (($urandom % 3) == 0) ? 4'hF : 4'($urandom);
         g  = (($urandom % 10) == 0);
         we = (($urandom % 4) == 0);
         step(s, g, we, 4'($urandom), "");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule